// File: doc/BRIEF.md
# Lane-Pairing Operand Forwarder and Result Comparator

This block sits beside a cluster of SIMT lanes, between register read and writeback. When a warp has diverged, some lanes are masked off and would sit idle. The block turns those idle lanes into redundant checkers. It reads the warp's active mask and pairs each active lane with an inactive lane. It then steers the active lane's source operands onto the paired inactive lane, so both lanes compute the same operation on the same inputs.

The pairing is registered and travels with the instruction down a pipeline of fixed depth. When the lane results reach writeback, each duplicate lane's result is compared with the result of the lane it copied. A mismatch in any duplicate lane produces a per-lane mismatch vector, an error flag and a one-cycle flush request.

The cluster width, the operand count, the data width and the execution latency are parameters. Clusters of 4 and 8 lanes are both supported.

Top module: `lane_dmr_fwd`

## Requirements
- R1: Lanes are ordered from the most significant lane down. The k-th active lane pairs with the k-th inactive lane. `dup_vld[i]` is 1 for every inactive lane i that has a partner, and `uncovered[j]` is 1 for every active lane j that is left without a partner. Both flags are valid in the issue cycle.
- R2: A duplicate lane's `fwd_opnd` carries all source operands of its partner lane. Every other lane's `fwd_opnd` equals its own `src_opnd`.
- R3: In a 4-lane cluster with mask 4'b1100, lane 1 receives the operands of lane 3 and lane 0 receives the operands of lane 2. Lanes 3 and 2 keep their own operands.
- R4: A mask of all ones or all zeros creates no duplicates. Such an instruction never causes an error, whatever its results are.
- R5: Results for an instruction issued in cycle c are presented on `wb_result` in cycle c+LAT. In cycle c+LAT+1, `mismatch_vec[i]` is 1 exactly when lane i was a duplicate of that instruction and its result differs from its partner's result.
- R6: `error` and `flush` are 1 during a cycle exactly when `mismatch_vec` is nonzero in that cycle. Each such assertion lasts one cycle per checked instruction.
- R7: The comparison uses the pairing captured at issue. Masks applied to later instructions do not change how an earlier instruction is checked.
- R8: While `issue_vld` is 0, `dup_vld` and `uncovered` are 0 and `fwd_opnd` equals `src_opnd`. No comparison is made LAT cycles later, whatever `wb_result` holds.
- R9: A synchronous reset clears `mismatch_vec`, `error` and `flush`. It also drops every instruction in flight, so none of them is checked afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | An instruction is in the register-read stage |
| active_mask | input | LANES | Warp active mask, one bit per lane |
| src_opnd | input | LANES*NSRC*DATA_W | Source operands read for each lane |
| fwd_opnd | output | LANES*NSRC*DATA_W | Operands delivered to each lane after forwarding |
| dup_vld | output | LANES | Lane runs as a duplicate for this issue |
| uncovered | output | LANES | Active lane that has no duplicate |
| wb_result | input | LANES*DATA_W | Lane results at writeback, LAT cycles after issue |
| mismatch_vec | output | LANES | Duplicate lanes whose result disagreed with the original |
| error | output | 1 | Any mismatch in the checked instruction |
| flush | output | 1 | One-cycle flush request on mismatch |

## Verification
The hardest case to reach is a duplicate-lane mismatch whose pairing differs from the mask on the ports at writeback time. It only shows up when the comparator uses a stale or current pairing instead of the one captured at issue. The stimulus issues back-to-back instructions with a fresh random mask every cycle, so the pairing at writeback almost never matches the pairing at issue. It then flips a random bit in some duplicate results and leaves the others matching. Directed steps cover the full and empty masks with unrelated results, idle cycles with garbage results, and a reset applied while a corrupted instruction is still in flight.

// File: rtl/lane_dmr_pkg.sv
`timescale 1ns/1ps
package lane_dmr_pkg;

    localparam int MAX_LANES = 32;

    typedef enum logic [1:0] {
        ROLE_SPARE = 2'd0,   // inactive, no partner
        ROLE_DUP   = 2'd1,   // inactive, duplicates an active lane
        ROLE_ORIG  = 2'd2,   // active, covered by a duplicate
        ROLE_UNCOV = 2'd3    // active, no duplicate left
    } lane_role_e;

    // number of set bits strictly above position lane
    function automatic int count_above(input logic [MAX_LANES-1:0] bits, input int lane);
        int c;
        c = 0;
        for (int k = 0; k < MAX_LANES; k++) begin
            if (k > lane && bits[k]) c++;
        end
        return c;
    endfunction

endpackage

// File: rtl/dmr_pair_map.sv
`timescale 1ns/1ps
module dmr_pair_map
    import lane_dmr_pkg::*;
#(
    parameter int LANES = 8,
    parameter int IDX_W = 3
) (
    input  logic [LANES-1:0]            mask,
    output lane_role_e [LANES-1:0]      role,
    output logic [LANES-1:0][IDX_W-1:0] partner
);

    logic [MAX_LANES-1:0] mask_ext;
    int n_act;
    int n_inact;
    int act_rank [LANES];

    assign mask_ext = MAX_LANES'(mask);

    always_comb begin
        n_act   = $countones(mask);
        n_inact = LANES - n_act;
        for (int i = 0; i < LANES; i++) begin
            act_rank[i] = count_above(mask_ext, i);
        end
        for (int i = 0; i < LANES; i++) begin
            partner[i] = '0;
            if (mask[i]) begin
                role[i] = (act_rank[i] < n_inact) ? ROLE_ORIG : ROLE_UNCOV;
            end else if (((LANES - 1 - i) - act_rank[i]) < n_act) begin
                role[i] = ROLE_DUP;
                for (int j = 0; j < LANES; j++) begin
                    if (mask[j] && act_rank[j] == ((LANES - 1 - i) - act_rank[i]))
                        partner[i] = IDX_W'(j);
                end
            end else begin
                role[i] = ROLE_SPARE;
            end
        end
    end

endmodule

// File: rtl/dmr_opnd_mux.sv
`timescale 1ns/1ps
module dmr_opnd_mux
    import lane_dmr_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int NSRC   = 2,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  lane_role_e [LANES-1:0]                     role,
    input  logic [LANES-1:0][IDX_W-1:0]                partner,
    input  logic [LANES-1:0][NSRC-1:0][DATA_W-1:0]     src_opnd,
    output logic [LANES-1:0][NSRC-1:0][DATA_W-1:0]     fwd_opnd
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign fwd_opnd[g] = (role[g] == ROLE_DUP) ? src_opnd[partner[g]] : src_opnd[g];
    end

endmodule

// File: rtl/dmr_pair_pipe.sv
`timescale 1ns/1ps
module dmr_pair_pipe #(
    parameter int LANES = 8,
    parameter int IDX_W = 3,
    parameter int LAT   = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_vld,
    input  logic [LANES-1:0]            in_dup,
    input  logic [LANES-1:0][IDX_W-1:0] in_par,
    output logic                        out_vld,
    output logic [LANES-1:0]            out_dup,
    output logic [LANES-1:0][IDX_W-1:0] out_par
);

    logic [LAT-1:0]                        vld_q;
    logic [LAT-1:0][LANES-1:0]             dup_q;
    logic [LAT-1:0][LANES-1:0][IDX_W-1:0]  par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            dup_q <= '0;
            par_q <= '0;
        end else begin
            vld_q[0] <= in_vld;
            dup_q[0] <= in_dup;
            par_q[0] <= in_par;
            for (int k = 1; k < LAT; k++) begin
                vld_q[k] <= vld_q[k-1];
                dup_q[k] <= dup_q[k-1];
                par_q[k] <= par_q[k-1];
            end
        end
    end

    assign out_vld = vld_q[LAT-1];
    assign out_dup = dup_q[LAT-1];
    assign out_par = par_q[LAT-1];

endmodule

// File: rtl/dmr_result_cmp.sv
`timescale 1ns/1ps
module dmr_result_cmp #(
    parameter int LANES  = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        chk_vld,
    input  logic [LANES-1:0]            chk_dup,
    input  logic [LANES-1:0][IDX_W-1:0] chk_par,
    input  logic [LANES-1:0][DATA_W-1:0] wb_result,
    output logic [LANES-1:0]            mismatch_vec,
    output logic                        error,
    output logic                        flush
);

    logic [LANES-1:0] mm_d;
    logic             err_q;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            mm_d[i] = chk_vld && chk_dup[i] && (wb_result[i] != wb_result[chk_par[i]]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mismatch_vec <= '0;
            err_q        <= 1'b0;
        end else begin
            mismatch_vec <= mm_d;
            err_q        <= |mm_d;
        end
    end

    assign error = err_q;
    assign flush = err_q;

    // R5
    mm_dup_only_chk: assert property (@(posedge clk) disable iff (rst)
        (mismatch_vec & ~$past(chk_dup)) == '0);

    // R8
    mm_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_vld |=> mismatch_vec == '0);

endmodule

// File: rtl/lane_dmr_fwd.sv
`timescale 1ns/1ps
module lane_dmr_fwd
    import lane_dmr_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int NSRC   = 2,
    parameter int DATA_W = 32,
    parameter int LAT    = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   issue_vld,
    input  logic [LANES-1:0]                       active_mask,
    input  logic [LANES-1:0][NSRC-1:0][DATA_W-1:0] src_opnd,
    output logic [LANES-1:0][NSRC-1:0][DATA_W-1:0] fwd_opnd,
    output logic [LANES-1:0]                       dup_vld,
    output logic [LANES-1:0]                       uncovered,
    input  logic [LANES-1:0][DATA_W-1:0]           wb_result,
    output logic [LANES-1:0]                       mismatch_vec,
    output logic                                   error,
    output logic                                   flush
);

    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LANES-1:0]            eff_mask;
    lane_role_e [LANES-1:0]      role;
    logic [LANES-1:0][IDX_W-1:0] partner;
    logic                        chk_vld;
    logic [LANES-1:0]            chk_dup;
    logic [LANES-1:0][IDX_W-1:0] chk_par;

    assign eff_mask = issue_vld ? active_mask : '0;

    dmr_pair_map #(.LANES(LANES), .IDX_W(IDX_W)) u_map (
        .mask    (eff_mask),
        .role    (role),
        .partner (partner)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_flag
        assign dup_vld[g]   = (role[g] == ROLE_DUP);
        assign uncovered[g] = (role[g] == ROLE_UNCOV);
    end

    dmr_opnd_mux #(.LANES(LANES), .NSRC(NSRC), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
        .role     (role),
        .partner  (partner),
        .src_opnd (src_opnd),
        .fwd_opnd (fwd_opnd)
    );

    dmr_pair_pipe #(.LANES(LANES), .IDX_W(IDX_W), .LAT(LAT)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (issue_vld),
        .in_dup  (dup_vld),
        .in_par  (partner),
        .out_vld (chk_vld),
        .out_dup (chk_dup),
        .out_par (chk_par)
    );

    dmr_result_cmp #(.LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_cmp (
        .clk          (clk),
        .rst          (rst),
        .chk_vld      (chk_vld),
        .chk_dup      (chk_dup),
        .chk_par      (chk_par),
        .wb_result    (wb_result),
        .mismatch_vec (mismatch_vec),
        .error        (error),
        .flush        (flush)
    );

    // R1
    dup_inactive_chk: assert property (@(posedge clk) disable iff (rst)
        (dup_vld & active_mask) == '0);

    // R1
    cover_count_chk: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> ($countones(dup_vld) + $countones(uncovered)) == $countones(active_mask));

    // R4
    full_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && ((&active_mask) || active_mask == '0)) |-> dup_vld == '0);

    // R8
    idle_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_vld |-> (dup_vld | uncovered) == '0);

    // R6
    err_after_chk_chk: assert property (@(posedge clk) disable iff (rst)
        error |-> $past(chk_vld));

endmodule

// File: tb/lane_dmr_fwd_tb_top.sv
`timescale 1ns/1ps
module lane_dmr_fwd_tb_top;

    localparam int L   = 8;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic                     issue_vld = 1'b0;
    logic [L-1:0]             active_mask = '0;
    logic [L-1:0][1:0][31:0]  src_opnd = '0;
    logic [L-1:0][1:0][31:0]  fwd_opnd;
    logic [L-1:0]             dup_vld, uncovered, mismatch_vec;
    logic [L-1:0][31:0]       wb_result = '0;
    logic                     error, flush;

    lane_dmr_fwd #(.LANES(L), .NSRC(2), .DATA_W(32), .LAT(LAT)) dut_i (
        .clk(clk), .rst(rst), .issue_vld(issue_vld), .active_mask(active_mask),
        .src_opnd(src_opnd), .fwd_opnd(fwd_opnd), .dup_vld(dup_vld),
        .uncovered(uncovered), .wb_result(wb_result), .mismatch_vec(mismatch_vec),
        .error(error), .flush(flush)
    );

    // 4-lane instance
    logic                    i4v = 1'b0;
    logic [3:0]              m4 = '0;
    logic [3:0][1:0][31:0]   s4 = '0;
    logic [3:0][1:0][31:0]   f4;
    logic [3:0]              d4, u4, mm4;
    logic [3:0][31:0]        wb4 = '0;
    logic                    e4, fl4;

    lane_dmr_fwd #(.LANES(4), .NSRC(2), .DATA_W(32), .LAT(LAT)) dut4_i (
        .clk(clk), .rst(rst), .issue_vld(i4v), .active_mask(m4),
        .src_opnd(s4), .fwd_opnd(f4), .dup_vld(d4), .uncovered(u4),
        .wb_result(wb4), .mismatch_vec(mm4), .error(e4), .flush(fl4)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic        hv [LAT];
    logic [L-1:0] hm [LAT];
    string       ht [LAT];
    logic [L-1:0] exp_mm = '0;
    string       tag_pend = "R9";

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference pairing: walk lanes from the top, list active and inactive ones
    function automatic void pair_model(input logic [L-1:0] m, output int part [L],
                                       output logic [L-1:0] dup, output logic [L-1:0] unc);
        int act_l [L];
        int ina_l [L];
        int na, ni;
        na = 0; ni = 0; dup = '0; unc = '0;
        for (int i = 0; i < L; i++) part[i] = i;
        for (int i = L - 1; i >= 0; i--) begin
            if (m[i]) begin act_l[na] = i; na++; end
            else      begin ina_l[ni] = i; ni++; end
        end
        for (int k = 0; k < na; k++) begin
            if (k < ni) begin
                part[ina_l[k]] = act_l[k];
                dup[ina_l[k]]  = 1'b1;
            end else begin
                unc[act_l[k]] = 1'b1;
            end
        end
    endfunction

    // cmode: 0 keep duplicates equal, 1 corrupt some, 2 corrupt all
    task automatic cycle(input string tag, input logic r, input logic iv,
                         input logic [L-1:0] m, input int cmode);
        int part [L];
        int hp [L];
        logic [L-1:0] dup, unc, hd, hu, nxt;
        @(negedge clk);
        check({tag_pend, " mismatch_vec"}, 64'(mismatch_vec), 64'(exp_mm));
        check({tag_pend, " error"}, 64'(error), 64'(|exp_mm));
        check({tag_pend, " flush"}, 64'(flush), 64'(|exp_mm));
        rst = r;
        issue_vld = iv;
        active_mask = m;
        for (int l = 0; l < L; l++) src_opnd[l] = {$urandom, $urandom};
        pair_model(hm[LAT-1], hp, hd, hu);
        for (int l = 0; l < L; l++) wb_result[l] = $urandom;
        for (int l = 0; l < L; l++) begin
            if (hd[l]) begin
                wb_result[l] = wb_result[hp[l]];
                if (cmode == 2 || (cmode == 1 && ($urandom % 3) == 0))
                    wb_result[l] = wb_result[l] ^ (32'h1 << ($urandom % 32));
            end
        end
        nxt = '0;
        for (int l = 0; l < L; l++)
            if (hv[LAT-1] && hd[l] && wb_result[l] != wb_result[hp[l]]) nxt[l] = 1'b1;
        exp_mm   = r ? '0 : nxt;
        tag_pend = r ? "R9" : ht[LAT-1];
        #1;
        pair_model(iv ? m : '0, part, dup, unc);
        check({tag, " dup_vld"}, 64'(dup_vld), 64'(dup));
        check({tag, " uncovered"}, 64'(uncovered), 64'(unc));
        for (int l = 0; l < L; l++)
            check({tag, " R2 fwd_opnd"}, fwd_opnd[l], dup[l] ? src_opnd[part[l]] : src_opnd[l]);
        for (int k = LAT - 1; k >= 1; k--) begin
            hv[k] = hv[k-1]; hm[k] = hm[k-1]; ht[k] = ht[k-1];
        end
        hv[0] = iv; hm[0] = m; ht[0] = tag;
        if (r) for (int k = 0; k < LAT; k++) hv[k] = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < LAT; k++) begin hv[k] = 1'b0; hm[k] = '0; ht[k] = "R9"; end
        repeat (2) @(posedge clk);
        // R9 reset state checked on first step
        cycle("R9", 1'b1, 1'b0, '0, 0);
        cycle("R9", 1'b0, 1'b0, '0, 0);

        // R3: 4-lane cluster, mask 1100
        @(negedge clk);
        i4v = 1'b1; m4 = 4'b1100;
        for (int l = 0; l < 4; l++) s4[l] = {$urandom, $urandom};
        #1;
        check("R3 dup4", 64'(d4), 64'h3);
        check("R3 lane1", f4[1], s4[3]);
        check("R3 lane0", f4[0], s4[2]);
        check("R3 lane3", f4[3], s4[3]);
        check("R3 lane2", f4[2], s4[2]);
        i4v = 1'b0;

        // R1 directed patterns
        cycle("R1 top-half", 1'b0, 1'b1, 8'b1111_0000, 1);
        cycle("R1 sparse", 1'b0, 1'b1, 8'b1010_0001, 2);
        cycle("R1 heavy", 1'b0, 1'b1, 8'b1110_1111, 2);
        // R4 full and empty masks with unrelated results
        cycle("R4 ones", 1'b0, 1'b1, 8'hFF, 2);
        cycle("R4 zeros", 1'b0, 1'b1, 8'h00, 2);
        // R8 idle with garbage results
        cycle("R8 idle", 1'b0, 1'b0, 8'h0F, 2);
        cycle("R8 idle", 1'b0, 1'b0, 8'h3C, 2);
        cycle("R6 single", 1'b0, 1'b1, 8'b0000_0001, 2);
        cycle("R8 idle", 1'b0, 1'b0, 8'h00, 0);
        cycle("R8 idle", 1'b0, 1'b0, 8'h00, 0);
        cycle("R8 idle", 1'b0, 1'b0, 8'h00, 0);

        // R7 with R5 and R6: back-to-back issues, fresh mask every cycle
        for (int n = 0; n < 2000; n++) begin
            logic [L-1:0] m;
            int sel;
            sel = $urandom % 10;
            m = (sel == 0) ? 8'hFF : (sel == 1) ? 8'h00 : L'($urandom);
            cycle("R5/R7 rand", 1'b0, ($urandom % 4) != 0, m, int'($urandom % 3));
        end

        // R9: reset while a corrupted instruction is in flight
        cycle("R9 inflight", 1'b0, 1'b1, 8'b1100_0000, 2);
        cycle("R9 rst", 1'b1, 1'b0, '0, 2);
        cycle("R9 rst", 1'b1, 1'b0, '0, 2);
        cycle("R9 after", 1'b0, 1'b0, '0, 2);
        cycle("R9 after", 1'b0, 1'b0, '0, 2);
        cycle("R9 after", 1'b0, 1'b0, '0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule